// File: doc/BRIEF.md
# Grouped Four-Bank Interrupt Controller

This block gathers interrupt request lines from four groups of sources: local bus peripherals, low-pin-count bus peripherals, PCI and on-chip devices, and non-maskable sources. Each group holds up to sixteen lines. For each line, software picks level or edge detection and the active polarity, and it can block the line with a mask bit. The block merges the unmasked pending lines into one bank-summary word and drives one interrupt line to the CPU.

Software reaches the block through a simple synchronous register port. Each bank has four registers: mask, trigger mode, polarity and pending request. One further address holds the bank summary. Software reads the summary once to pick the highest-priority bank, then reads that bank's pending register to find the lowest set line. The low-pin-count bank is acknowledged by writing its pending register. In the other banks, a latched edge is dropped by switching the line back to level mode.

Top module: `irqc_top`

## Requirements
- R1: After reset every mask register reads 0xFFFF, every trigger and polarity register reads 0x0000, the summary reads 0 and irq_o is low.
- R2: A mask bit of 1 keeps its line out of the summary and out of irq_o. A mask bit of 0 lets a pending line through.
- R3: In level mode (trigger bit 0), a pending bit follows the line: a polarity bit of 1 means the line is active high, and 0 means active low. The pending bit clears when the line goes inactive.
- R4: In edge mode (trigger bit 1), an inactive-to-active transition sets the pending bit. The bit stays set after the line returns inactive.
- R5: The summary register sits at address 16. Bit 0 is the local bus bank, bit 1 the low-pin-count bank, bit 2 the PCI/device bank and bit 3 the NMI bank. A summary bit is 1 when that bank has any pending bit whose mask bit is 0. Bits 15:4 read 0.
- R6: irq_o is high exactly when at least one summary bit is set.
- R7: A write to the low-pin-count pending register (address 7) clears each latched edge request whose write-data bit is 0 and keeps those whose bit is 1. Writing 0 clears them all.
- R8: An edge that is detected in the same cycle as a clearing write to the low-pin-count pending register stays latched.
- R9: Writes to the pending registers of the local bus, PCI and NMI banks (addresses 3, 11, 15) leave the pending bits unchanged.
- R10: Bank registers sit at address bank*4 + reg, where reg 0 is mask, 1 is trigger, 2 is polarity and 3 is pending. Read data appears on rdata_o on the clock edge that samples rd_en_i. Addresses above 16 read 0.
- R11: Setting an edge-mode line back to level mode discards its latched request.
- R12: A line change goes through a two-flop synchroniser. In level mode, irq_o still shows the old state after the first clock edge and the new state after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| lb_src_i | input | 16 | Raw local bus request lines |
| lpc_src_i | input | 16 | Raw low-pin-count request lines |
| pci_src_i | input | 16 | Raw PCI/device request lines |
| nmi_src_i | input | 16 | Raw NMI request lines |
| rdata_o | output | 16 | Read data, registered |
| irq_o | output | 1 | Combined interrupt to the CPU |

## Verification
The hardest case to reach from the ports is an edge reaching the latch in the very cycle that a clearing write lands. The input change has to be timed from the synchroniser depth. The bench raises a low-pin-count line on a falling clock edge and lets two rising edges pass. It then holds the clearing write across the third rising edge, which is the cycle in which the edge is detected. A second line was latched beforehand. After the write, that older request must be gone while the new one remains. Sweeps over every bank and line check level, polarity, mask and edge behaviour, with expected words built as single-bit shifts.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BANKS    = 4;
  localparam int BANK_LB  = 0;
  localparam int BANK_LPC = 1;
  localparam int BANK_PCI = 2;
  localparam int BANK_NMI = 3;
  localparam int REGS_PER_BANK = 4;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_TRIG = 2'd1,
    REG_POL  = 2'd2,
    REG_REQ  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int W            = 16,
  parameter bit CLR_BY_WRITE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic         cfg_we_i,
  input  reg_sel_e     cfg_sel_i,
  input  logic [W-1:0] cfg_wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] trig_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] req_o,
  output logic         pend_o
);
  logic [W-1:0] sync_w;
  logic [W-1:0] active_w;
  logic [W-1:0] edge_w;
  logic [W-1:0] clr_w;

  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] trig_q, trig_d;
  logic [W-1:0] pol_q, pol_d;
  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] latch_q, latch_d;
  logic         mask_en, trig_en, pol_en;

  irqc_sync #(.W(W)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_w)
  );

  assign mask_en = cfg_we_i && (cfg_sel_i == REG_MASK);
  assign trig_en = cfg_we_i && (cfg_sel_i == REG_TRIG);
  assign pol_en  = cfg_we_i && (cfg_sel_i == REG_POL);

  // polarity bit 1: active high, 0: active low
  assign active_w = ~(sync_w ^ pol_q);
  assign edge_w   = active_w & ~prev_q;

  generate
    if (CLR_BY_WRITE) begin : g_wclr
      assign clr_w = (cfg_we_i && (cfg_sel_i == REG_REQ)) ? ~cfg_wdata_i : '0;
    end else begin : g_noclr
      assign clr_w = '0;
    end
  endgenerate

  always_comb begin
    mask_d  = mask_en ? cfg_wdata_i : mask_q;
    trig_d  = trig_en ? cfg_wdata_i : trig_q;
    pol_d   = pol_en  ? cfg_wdata_i : pol_q;
    prev_d  = active_w;
    // new edge wins over a clear in the same cycle; level mode drops the latch
    latch_d = trig_q & ((latch_q & ~clr_w) | edge_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      trig_q  <= '0;
      pol_q   <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      mask_q  <= mask_d;
      trig_q  <= trig_d;
      pol_q   <= pol_d;
      prev_q  <= prev_d;
      latch_q <= latch_d;
    end
  end

  assign req_o  = (trig_q & latch_q) | (~trig_q & active_w);
  assign pend_o = |(req_o & ~mask_q);
  assign mask_o = mask_q;
  assign trig_o = trig_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINES-1:0]  wdata_i,
  input  logic [LINES-1:0]  lb_src_i,
  input  logic [LINES-1:0]  lpc_src_i,
  input  logic [LINES-1:0]  pci_src_i,
  input  logic [LINES-1:0]  nmi_src_i,
  output logic [LINES-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int SUMMARY_ADDR = BANKS * REGS_PER_BANK;
  localparam logic [ADDR_W-1:0] SUM_A = ADDR_W'(SUMMARY_ADDR);
  localparam int SEL_W  = $clog2(REGS_PER_BANK);
  localparam int BANK_W = $clog2(BANKS);

  logic rst_meta_q, rst_n_q;

  logic [BANKS-1:0][LINES-1:0] src_w;
  logic [BANKS-1:0][LINES-1:0] mask_w;
  logic [BANKS-1:0][LINES-1:0] trig_w;
  logic [BANKS-1:0][LINES-1:0] pol_w;
  logic [BANKS-1:0][LINES-1:0] req_w;
  logic [BANKS-1:0]            summary_w;
  logic [BANKS-1:0]            bank_we_w;

  logic              in_banks_w;
  logic [BANK_W-1:0] bank_idx_w;
  reg_sel_e          sel_w;
  logic [LINES-1:0]  rdata_d, rdata_q, rdata_nx;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  assign src_w[BANK_LB]  = lb_src_i;
  assign src_w[BANK_LPC] = lpc_src_i;
  assign src_w[BANK_PCI] = pci_src_i;
  assign src_w[BANK_NMI] = nmi_src_i;

  assign in_banks_w = addr_i < SUM_A;
  assign bank_idx_w = addr_i[SEL_W +: BANK_W];
  assign sel_w      = reg_sel_e'(addr_i[SEL_W-1:0]);

  genvar g;
  generate
    for (g = 0; g < BANKS; g++) begin : g_bank
      assign bank_we_w[g] = wr_en_i && in_banks_w && (bank_idx_w == BANK_W'(g));

      irqc_bank #(
        .W           (LINES),
        .CLR_BY_WRITE(g == BANK_LPC)
      ) bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_n_q),
        .raw_i      (src_w[g]),
        .cfg_we_i   (bank_we_w[g]),
        .cfg_sel_i  (sel_w),
        .cfg_wdata_i(wdata_i),
        .mask_o     (mask_w[g]),
        .trig_o     (trig_w[g]),
        .pol_o      (pol_w[g]),
        .req_o      (req_w[g]),
        .pend_o     (summary_w[g])
      );
    end
  endgenerate

  assign irq_o = |summary_w;

  always_comb begin
    rdata_d = '0;
    if (addr_i == SUM_A) begin
      rdata_d[BANKS-1:0] = summary_w;
    end else if (in_banks_w) begin
      unique case (sel_w)
        REG_MASK: rdata_d = mask_w[bank_idx_w];
        REG_TRIG: rdata_d = trig_w[bank_idx_w];
        REG_POL:  rdata_d = pol_w[bank_idx_w];
        REG_REQ:  rdata_d = req_w[bank_idx_w];
        default:  rdata_d = '0;
      endcase
    end
    rdata_nx = rd_en_i ? rdata_d : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_nx;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 5
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        rd_en_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [LINES-1:0]            rdata_i,
  input logic                        irq_i,
  input logic [BANKS-1:0]            summary_i,
  input logic [BANKS-1:0][LINES-1:0] mask_i,
  input logic [BANKS-1:0][LINES-1:0] trig_i,
  input logic [BANKS-1:0][LINES-1:0] req_i
);
  localparam logic [ADDR_W-1:0] SUM_A = ADDR_W'(BANKS * REGS_PER_BANK);

  logic [LINES-1:0] open_any;
  always_comb begin
    open_any = '0;
    for (int b = 0; b < BANKS; b++) open_any |= req_i[b] & ~mask_i[b];
  end

  // R6: the CPU line only rises with an unmasked pending bit somewhere
  assert_irq_has_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (open_any != '0));

  // R10: summary read returns the value seen on the sampling edge
  assert_read_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == SUM_A) |=> (rdata_i == {{(LINES-BANKS){1'b0}}, $past(summary_i)}));

  genvar g;
  generate
    for (g = 0; g < BANKS; g++) begin : g_chk
      // R2: a fully masked bank never shows in the summary
      assert_masked_bank_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i[g] == '1) |-> !summary_i[g]);
      if (g != BANK_LPC) begin : g_hold
        // R4: an edge latch outside the LPC bank holds while edge mode stays on
        assert_edge_latch_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
          ((($past(req_i[g]) & $past(trig_i[g]) & trig_i[g]) & ~req_i[g]) == '0));
      end
    end
  endgenerate
endmodule

bind irqc_top irqc_checker #(.LINES(LINES), .ADDR_W(ADDR_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_n_q),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .rdata_i  (rdata_o),
  .irq_i    (irq_o),
  .summary_i(summary_w),
  .mask_i   (mask_w),
  .trig_i   (trig_w),
  .req_i    (req_w)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int AW = 5;
  localparam logic [AW-1:0] SUM_A = 5'd16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [LINES-1:0] wdata, rdata;
  logic irq;
  logic [3:0][LINES-1:0] src;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  irqc_top #(.LINES(LINES), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata),
    .lb_src_i(src[0]), .lpc_src_i(src[1]), .pci_src_i(src[2]), .nmi_src_i(src[3]),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [AW-1:0] ra(int b, int r);
    return AW'(b * 4 + r);
  endfunction

  task automatic chk(string tag, logic [LINES-1:0] act, logic [LINES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [LINES-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [LINES-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [LINES-1:0] v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; src = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int b = 0; b < 4; b++) begin
      rd(ra(b, 0), v); chk("R1 mask", v, 16'hFFFF);
      rd(ra(b, 1), v); chk("R1 trig", v, 16'h0000);
      rd(ra(b, 2), v); chk("R1 pol", v, 16'h0000);
    end
    rd(SUM_A, v); chk("R1 summary", v, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    for (int b = 0; b < 4; b++) wr(ra(b, 2), 16'hFFFF);
    idle(4);
    rd(ra(1, 2), v); chk("R10 pol readback", v, 16'hFFFF);
    rd(5'd20, v); chk("R10 unused addr", v, 16'h0);

    // level sweep: R2 R3 R5 R6
    for (int b = 0; b < 4; b++) begin
      for (int l = 0; l < LINES; l++) begin
        wr(ra(b, 0), ~(16'h1 << l));
        src[b][l] = 1'b1;
        idle(3);
        rd(ra(b, 3), v); chk("R3 level set", v, 16'h1 << l);
        rd(SUM_A, v);    chk("R5 summary bit", v, 16'h1 << b);
        chk("R6 irq high", {15'b0, irq}, 16'h1);
        wr(ra(b, 0), 16'hFFFF);
        idle(1);
        rd(SUM_A, v); chk("R2 masked summary", v, 16'h0);
        chk("R2 masked irq", {15'b0, irq}, 16'h0);
        src[b][l] = 1'b0;
        idle(3);
        rd(ra(b, 3), v); chk("R3 level clear", v, 16'h0);
      end
    end

    // R3 active-low line
    wr(ra(2, 2), ~(16'h1 << 5));
    idle(3);
    rd(ra(2, 3), v); chk("R3 active low idle", v, 16'h0020);
    src[2][5] = 1'b1;
    idle(3);
    rd(ra(2, 3), v); chk("R3 active low driven", v, 16'h0000);
    src[2][5] = 1'b0;
    wr(ra(2, 2), 16'hFFFF);
    idle(3);

    // R12 synchroniser depth
    wr(ra(0, 0), ~16'h0008);
    src[0][3] = 1'b1;
    @(negedge clk); chk("R12 after one edge", {15'b0, irq}, 16'h0);
    @(negedge clk); chk("R12 after two edges", {15'b0, irq}, 16'h1);
    src[0][3] = 1'b0;
    wr(ra(0, 0), 16'hFFFF);
    idle(3);

    // edge sweep: R4 R7 R9 R11
    for (int b = 0; b < 4; b++) begin
      for (int l = 0; l < LINES; l++) begin
        wr(ra(b, 1), 16'h1 << l);
        src[b][l] = 1'b1;
        @(negedge clk);
        src[b][l] = 1'b0;
        idle(4);
        rd(ra(b, 3), v); chk("R4 edge latched", v, 16'h1 << l);
        if (b == 1) begin
          wr(ra(b, 3), 16'h0);
          rd(ra(b, 3), v); chk("R7 clear all", v, 16'h0);
        end else begin
          wr(ra(b, 3), 16'h0);
          rd(ra(b, 3), v); chk("R9 write ignored", v, 16'h1 << l);
          wr(ra(b, 1), 16'h0);
          wr(ra(b, 1), 16'h1 << l);
          rd(ra(b, 3), v); chk("R11 level discards latch", v, 16'h0);
        end
        wr(ra(b, 1), 16'h0);
      end
    end

    // R7 selective clear
    wr(ra(1, 1), 16'h0003);
    src[1][1:0] = 2'b11;
    @(negedge clk);
    src[1][1:0] = 2'b00;
    idle(4);
    rd(ra(1, 3), v); chk("R7 both latched", v, 16'h0003);
    wr(ra(1, 3), 16'h0002);
    rd(ra(1, 3), v); chk("R7 keep ones", v, 16'h0002);
    wr(ra(1, 3), 16'h0000);
    rd(ra(1, 3), v); chk("R7 zero clears", v, 16'h0000);

    // R8 edge in the cycle of the clear
    wr(ra(1, 1), 16'h0011);
    src[1][4] = 1'b1;
    @(negedge clk);
    src[1][4] = 1'b0;
    idle(4);
    rd(ra(1, 3), v); chk("R8 older latched", v, 16'h0010);
    src[1][0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = ra(1, 3); wdata = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    src[1][0] = 1'b0;
    rd(ra(1, 3), v); chk("R8 coincident edge kept", v, 16'h0001);
    wr(ra(1, 0), 16'hFFFE);
    idle(1);
    chk("R6 lpc edge irq", {15'b0, irq}, 16'h1);
    rd(SUM_A, v); chk("R5 lpc summary", v, 16'h0002);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule